// File: doc/BRIEF.md
# Paired Floating-Point Load Control Unit

This block sits between instruction issue and the data memory port and prepares a paired floating-point load. For each request it decodes the load form (single, double or integer), maps both logical target register numbers to physical numbers through the rotating-register base, checks that the pair is legal, and decides whether a NaT on the base register must fault or be deferred. When the load may proceed it emits a one-cycle memory request carrying the start address and the byte count, together with the two physical slots that receive the low-address and the high-address halves.

One cycle after the memory request it presents the result of the instruction. This result holds the fault and deferral flags, the post-incremented base value with its write-enable, and the two partition-modified status flags. Memory, format conversion and the register file are outside this block. A request is accepted in every cycle that its valid input is high, and requests may arrive back to back.

Top module: `fpair_load_ctl`

## Requirements
- R1: The form code (00 single, 01 double, 10 integer) sets the byte count of the memory request: 8 for single, 16 for double and integer.
- R2: A request sampled at a rising edge produces `mem_valid_o` high for exactly the following cycle, with `mem_addr_o` equal to the base value. The result outputs (`res_valid_o` and flags) are valid for the cycle after that. Both valids are low after reset.
- R3: `lo_slot_o` is the physical number of the first target and receives the lowest-address value. `hi_slot_o` is the physical number of the second target and receives the highest-address value.
- R4: Logical registers 0 to 31 map to themselves. A logical register n of 32 or above maps to 32 + ((n - 32 + rrb) mod 96), with rrb in 0 to 95.
- R5: With the update flag set, `base_we_o` is high and `base_wdata_o` is the original base plus the byte count (8 or 16), wrapping at the address width. With the flag clear, `base_we_o` is low. The memory address is always the un-incremented base.
- R6: A set base NaT on a class 00 (plain) or 01 (advanced) load raises `nat_fault_o`.
- R7: A set base NaT on a class 10 (speculative) or 11 (speculative advanced) load raises `deferred_o` and no fault. No memory request is issued. The base update and the status flags still take effect.
- R8: Two physical targets of equal parity (bit 0) raise `illop_fault_o`. Because the check is on physical numbers, one static and one rotating target with an odd rrb require logical numbers of equal parity.
- R9: A physical target equal to 0 or 1 raises `illop_fault_o`.
- R10: `mod_lo_o` is set when either target lies in 2..31. `mod_hi_o` is set when either target lies in 32..127.
- R11: `illop_fault_o` or `nat_fault_o` suppresses the memory request, the base write and both status flags. At most one of `illop_fault_o`, `nat_fault_o` and `deferred_o` is set, and the illegal-operation fault wins over the NaT outcomes.
- R12: Form code 11 is undefined and raises `illop_fault_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Load request valid |
| req_form_i | input | 2 | Form code |
| req_upd_i | input | 1 | Base post-increment enable |
| req_class_i | input | 2 | Speculation class |
| req_f1_i | input | 7 | First logical target |
| req_f2_i | input | 7 | Second logical target |
| req_base_i | input | 64 | Base register value |
| req_base_nat_i | input | 1 | NaT bit of the base register |
| req_rrb_i | input | 7 | Rotating-register base (0 to 95) |
| mem_valid_o | output | 1 | One-cycle memory request |
| mem_addr_o | output | 64 | Access start address |
| mem_bytes_o | output | 5 | Access byte count |
| lo_slot_o | output | 7 | Physical target for the low-address value |
| hi_slot_o | output | 7 | Physical target for the high-address value |
| res_valid_o | output | 1 | Result valid |
| base_we_o | output | 1 | Base register write-enable |
| base_wdata_o | output | 64 | Post-incremented base value |
| illop_fault_o | output | 1 | Illegal-operation fault |
| nat_fault_o | output | 1 | NaT consumption fault |
| deferred_o | output | 1 | NaT exception deferred |
| mod_lo_o | output | 1 | Low partition modified |
| mod_hi_o | output | 1 | High partition modified |

## Verification
The assertions check properties that hold on every cycle:
- a faulted or deferred result never follows a memory request;
- every memory request is followed by a result;
- a memory request always carries a legal byte count and two reserved-free slots of opposite parity;
- at most one fault or deferral outcome is flagged;
- a base write never accompanies a fault.

Other behaviour depends on the actual values and can only be shown by the bench's scenarios: the rotation arithmetic including the wrap at 96, the static-plus-rotating parity case with odd and even rotation bases, the exact post-increment value and its wrap, the split between NaT fault and deferral across all four classes, and back-to-back requests.

// File: rtl/fpair_pkg.sv
// Package: shared encodings for the paired floating-point load control unit.
// Assumes form and class codes arrive as 2-bit fields from the decoder.
package fpair_pkg;

    typedef enum logic [1:0] {
        FORM_SGL = 2'b00,
        FORM_DBL = 2'b01,
        FORM_INT = 2'b10,
        FORM_BAD = 2'b11
    } form_e;

    typedef enum logic [1:0] {
        CLS_PLAIN = 2'b00,
        CLS_ADV   = 2'b01,
        CLS_SPEC  = 2'b10,
        CLS_SPADV = 2'b11
    } ldcls_e;

    // A class defers a NaT exception when its speculative bit is set.
    function automatic logic cls_defers(ldcls_e c);
        return c[1];
    endfunction

endpackage

// File: rtl/fpair_rot_map.sv
// Module: maps one logical FP register number to its physical number.
// Registers below NUM_STATIC map to themselves. The rest rotate by rrb
// modulo NUM_ROT. Assumes rrb_i < NUM_ROT. Purely combinational.
module fpair_rot_map #(
    parameter int REG_W      = 7,
    parameter int NUM_STATIC = 32,
    parameter int NUM_ROT    = 96
) (
    input  logic [REG_W-1:0] logical_i,
    input  logic [REG_W-1:0] rrb_i,
    output logic [REG_W-1:0] phys_o
);
    localparam int SUM_W = REG_W + 1;

    logic             is_rot;
    logic [SUM_W-1:0] offs;
    logic [SUM_W-1:0] raw_sum;
    logic [SUM_W-1:0] wrapped;

    // Compute the rotated index and pick static or rotated result.
    always_comb begin
        is_rot  = (logical_i >= REG_W'(NUM_STATIC));
        offs    = {1'b0, logical_i} - SUM_W'(NUM_STATIC);
        raw_sum = offs + {1'b0, rrb_i};
        wrapped = (raw_sum >= SUM_W'(NUM_ROT)) ? (raw_sum - SUM_W'(NUM_ROT)) : raw_sum;
        phys_o  = is_rot ? REG_W'(wrapped + SUM_W'(NUM_STATIC)) : logical_i;
    end

endmodule

// File: rtl/fpair_pair_check.sv
// Module: legality and partition classification of a physical target pair.
// Flags equal parity or a reserved register (below NUM_RSVD) as illegal.
// Reports which partitions the pair touches. Combinational.
module fpair_pair_check #(
    parameter int REG_W      = 7,
    parameter int NUM_STATIC = 32,
    parameter int NUM_RSVD   = 2
) (
    input  logic [REG_W-1:0] phys_lo_i,
    input  logic [REG_W-1:0] phys_hi_i,
    output logic             bad_o,
    output logic             touch_lo_o,
    output logic             touch_hi_o
);
    localparam int NT = 2;

    logic [REG_W-1:0] phys [NT];
    logic [NT-1:0]    rsvd;
    logic [NT-1:0]    in_lo;
    logic [NT-1:0]    in_hi;

    assign phys[0] = phys_lo_i;
    assign phys[1] = phys_hi_i;

    // Classify each target independently.
    for (genvar g = 0; g < NT; g++) begin : g_cls
        always_comb begin
            rsvd[g]  = (phys[g] < REG_W'(NUM_RSVD));
            in_hi[g] = (phys[g] >= REG_W'(NUM_STATIC));
            in_lo[g] = !rsvd[g] && !in_hi[g];
        end
    end

    // Combine the per-target classes into pair results.
    always_comb begin
        bad_o      = (phys[0][0] == phys[1][0]) || (|rsvd);
        touch_lo_o = |in_lo;
        touch_hi_o = |in_hi;
    end

endmodule

// File: rtl/fpair_access_gen.sv
// Module: derives the byte count and the post-incremented base from the form.
// The increment equals the pair size (twice the element size). The undefined
// form code is flagged here. Combinational.
module fpair_access_gen
    import fpair_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int SGL_BYTES = 8,
    parameter int DBL_BYTES = 16,
    parameter int CNT_W     = $clog2(DBL_BYTES + 1)
) (
    input  form_e             form_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [CNT_W-1:0]  bytes_o,
    output logic [ADDR_W-1:0] next_base_o,
    output logic              form_bad_o
);
    // Select the pair size and flag the reserved code.
    always_comb begin
        form_bad_o = 1'b0;
        unique case (form_i)
            FORM_SGL: bytes_o = CNT_W'(SGL_BYTES);
            FORM_DBL,
            FORM_INT: bytes_o = CNT_W'(DBL_BYTES);
            default: begin
                bytes_o    = CNT_W'(DBL_BYTES);
                form_bad_o = 1'b1;
            end
        endcase
    end

    // Post-increment the base by the pair size, wrapping at ADDR_W.
    always_comb next_base_o = base_i + ADDR_W'(bytes_o);

endmodule

// File: rtl/fpair_load_ctl.sv
// Module: top of the paired FP load control unit.
// Stage 1 registers the memory request; stage 2 registers the instruction
// result one cycle later. Assumes req_rrb_i < NUM_ROT and no back-pressure
// (every valid request is accepted).
module fpair_load_ctl
    import fpair_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int REG_W      = 7,
    parameter int NUM_STATIC = 32,
    parameter int NUM_ROT    = 96,
    parameter int NUM_RSVD   = 2,
    parameter int SGL_BYTES  = 8,
    parameter int DBL_BYTES  = 16,
    localparam int CNT_W     = $clog2(DBL_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [1:0]        req_form_i,
    input  logic              req_upd_i,
    input  logic [1:0]        req_class_i,
    input  logic [REG_W-1:0]  req_f1_i,
    input  logic [REG_W-1:0]  req_f2_i,
    input  logic [ADDR_W-1:0] req_base_i,
    input  logic              req_base_nat_i,
    input  logic [REG_W-1:0]  req_rrb_i,
    output logic              mem_valid_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [CNT_W-1:0]  mem_bytes_o,
    output logic [REG_W-1:0]  lo_slot_o,
    output logic [REG_W-1:0]  hi_slot_o,
    output logic              res_valid_o,
    output logic              base_we_o,
    output logic [ADDR_W-1:0] base_wdata_o,
    output logic              illop_fault_o,
    output logic              nat_fault_o,
    output logic              deferred_o,
    output logic              mod_lo_o,
    output logic              mod_hi_o
);
    localparam int NT = 2;

    logic [REG_W-1:0]  logical [NT];
    logic [REG_W-1:0]  phys    [NT];
    logic              pair_bad, touch_lo, touch_hi;
    logic [CNT_W-1:0]  nbytes;
    logic [ADDR_W-1:0] next_base;
    logic              form_bad;
    logic              illop, natf, defer, issue, commit;

    // Stage-1 result bookkeeping carried to stage 2.
    logic              s1_valid, s1_we, s1_illop, s1_natf, s1_defer, s1_mlo, s1_mhi;
    logic [ADDR_W-1:0] s1_wdata;

    assign logical[0] = req_f1_i;
    assign logical[1] = req_f2_i;

    // One rotation mapper per target.
    for (genvar g = 0; g < NT; g++) begin : g_map
        fpair_rot_map #(
            .REG_W(REG_W), .NUM_STATIC(NUM_STATIC), .NUM_ROT(NUM_ROT)
        ) u_map (
            .logical_i(logical[g]),
            .rrb_i    (req_rrb_i),
            .phys_o   (phys[g])
        );
    end

    fpair_pair_check #(
        .REG_W(REG_W), .NUM_STATIC(NUM_STATIC), .NUM_RSVD(NUM_RSVD)
    ) u_chk (
        .phys_lo_i (phys[0]),
        .phys_hi_i (phys[1]),
        .bad_o     (pair_bad),
        .touch_lo_o(touch_lo),
        .touch_hi_o(touch_hi)
    );

    fpair_access_gen #(
        .ADDR_W(ADDR_W), .SGL_BYTES(SGL_BYTES), .DBL_BYTES(DBL_BYTES), .CNT_W(CNT_W)
    ) u_acc (
        .form_i     (form_e'(req_form_i)),
        .base_i     (req_base_i),
        .bytes_o    (nbytes),
        .next_base_o(next_base),
        .form_bad_o (form_bad)
    );

    // Arbitrate faults: illegal operation first, then the NaT fault or deferral.
    always_comb begin
        illop  = pair_bad || form_bad;
        natf   = !illop && req_base_nat_i && !cls_defers(ldcls_e'(req_class_i));
        defer  = !illop && req_base_nat_i &&  cls_defers(ldcls_e'(req_class_i));
        issue  = req_valid_i && !illop && !req_base_nat_i;
        commit = !illop && !natf;
    end

    // Stage 1: memory request and the registered decode results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid_o <= 1'b0;
            mem_addr_o  <= '0;
            mem_bytes_o <= '0;
            lo_slot_o   <= '0;
            hi_slot_o   <= '0;
            s1_valid    <= 1'b0;
            s1_we       <= 1'b0;
            s1_wdata    <= '0;
            s1_illop    <= 1'b0;
            s1_natf     <= 1'b0;
            s1_defer    <= 1'b0;
            s1_mlo      <= 1'b0;
            s1_mhi      <= 1'b0;
        end else begin
            mem_valid_o <= issue;
            s1_valid    <= req_valid_i;
            if (req_valid_i) begin
                mem_addr_o  <= req_base_i;
                mem_bytes_o <= nbytes;
                lo_slot_o   <= phys[0];
                hi_slot_o   <= phys[1];
                s1_we       <= req_upd_i && commit;
                s1_wdata    <= next_base;
                s1_illop    <= illop;
                s1_natf     <= natf;
                s1_defer    <= defer;
                s1_mlo      <= touch_lo && commit;
                s1_mhi      <= touch_hi && commit;
            end
        end
    end

    // Stage 2: instruction result, one cycle after the memory request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o   <= 1'b0;
            base_we_o     <= 1'b0;
            base_wdata_o  <= '0;
            illop_fault_o <= 1'b0;
            nat_fault_o   <= 1'b0;
            deferred_o    <= 1'b0;
            mod_lo_o      <= 1'b0;
            mod_hi_o      <= 1'b0;
        end else begin
            res_valid_o   <= s1_valid;
            base_we_o     <= s1_valid && s1_we;
            base_wdata_o  <= s1_wdata;
            illop_fault_o <= s1_valid && s1_illop;
            nat_fault_o   <= s1_valid && s1_natf;
            deferred_o    <= s1_valid && s1_defer;
            mod_lo_o      <= s1_valid && s1_mlo;
            mod_hi_o      <= s1_valid && s1_mhi;
        end
    end

    // R11
    fault_blocks_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o && (illop_fault_o || nat_fault_o || deferred_o) |-> !$past(mem_valid_o));

    // R2
    mem_then_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o |=> res_valid_o);

    // R11
    fault_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({illop_fault_o, nat_fault_o, deferred_o}));

    // R11
    we_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_we_o |-> res_valid_o && !illop_fault_o && !nat_fault_o);

    // R8
    slot_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o |-> lo_slot_o[0] != hi_slot_o[0]);

    // R9
    no_rsvd_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o |-> lo_slot_o >= REG_W'(NUM_RSVD) && hi_slot_o >= REG_W'(NUM_RSVD));

    // R1
    bytes_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o |-> mem_bytes_o == CNT_W'(SGL_BYTES) || mem_bytes_o == CNT_W'(DBL_BYTES));

endmodule

// File: tb/fpair_load_ctl_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard for the paired FP load control unit.
// The driver pushes expected items; the monitor pops and compares them.
module fpair_load_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [1:0]  req_form_i = '0;
    logic        req_upd_i = 1'b0;
    logic [1:0]  req_class_i = '0;
    logic [6:0]  req_f1_i = '0;
    logic [6:0]  req_f2_i = '0;
    logic [63:0] req_base_i = '0;
    logic        req_base_nat_i = 1'b0;
    logic [6:0]  req_rrb_i = '0;
    logic        mem_valid_o;
    logic [63:0] mem_addr_o;
    logic [4:0]  mem_bytes_o;
    logic [6:0]  lo_slot_o, hi_slot_o;
    logic        res_valid_o, base_we_o;
    logic [63:0] base_wdata_o;
    logic        illop_fault_o, nat_fault_o, deferred_o, mod_lo_o, mod_hi_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    typedef struct {
        int          cyc;
        string       tag;
        logic        mv;
        logic [63:0] addr;
        logic [4:0]  bytes;
        logic [6:0]  lo, hi;
        logic        we;
        logic [63:0] wd;
        logic        il, nf, df, ml, mh;
    } exp_t;

    exp_t mq[$];
    exp_t rq[$];

    fpair_load_ctl dut_i (.*);

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Reference mapping (R4).
    function automatic int pmap(int l, int rrb);
        if (l < 32) return l;
        return 32 + ((l - 32 + rrb) % 96);
    endfunction

    // Drive one request and push its expected outcome.
    task automatic issue(input string tag, input int form, input bit upd, input int cls,
                         input int f1, input int f2, input logic [63:0] base,
                         input bit nat, input int rrb);
        exp_t e;
        int p1, p2;
        @(negedge clk);
        req_valid_i = 1'b1; req_form_i = 2'(form); req_upd_i = upd;
        req_class_i = 2'(cls); req_f1_i = 7'(f1); req_f2_i = 7'(f2);
        req_base_i = base; req_base_nat_i = nat; req_rrb_i = 7'(rrb);
        p1 = pmap(f1, rrb);
        p2 = pmap(f2, rrb);
        e.cyc   = cyc;
        e.tag   = tag;
        e.il    = (form == 3) || ((p1 % 2) == (p2 % 2)) || p1 < 2 || p2 < 2;
        e.nf    = !e.il && nat && (cls < 2);
        e.df    = !e.il && nat && (cls >= 2);
        e.mv    = !e.il && !nat;
        e.addr  = base;
        e.bytes = (form == 0) ? 5'd8 : 5'd16;
        e.lo    = 7'(p1);
        e.hi    = 7'(p2);
        e.we    = upd && !e.il && !e.nf;
        e.wd    = base + 64'(e.bytes);
        e.ml    = !e.il && !e.nf && ((p1 >= 2 && p1 < 32) || (p2 >= 2 && p2 < 32));
        e.mh    = !e.il && !e.nf && (p1 >= 32 || p2 >= 32);
        mq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid_i = 1'b0;
        end
    endtask

    // Monitor: compares outputs one and two cycles after each request.
    initial begin
        exp_t e;
        wait (rst_n);
        forever begin
            @(posedge clk);
            #1;
            if (mq.size() > 0 && mq[0].cyc == cyc - 1) begin
                e = mq.pop_front();
                chk({e.tag, " mem_valid R11"}, 64'(mem_valid_o), 64'(e.mv));
                if (e.mv) begin
                    chk({e.tag, " bytes R1"}, 64'(mem_bytes_o), 64'(e.bytes));
                    chk({e.tag, " addr R2"}, mem_addr_o, e.addr);
                    chk({e.tag, " lo_slot R3"}, 64'(lo_slot_o), 64'(e.lo));
                    chk({e.tag, " hi_slot R3"}, 64'(hi_slot_o), 64'(e.hi));
                end
                rq.push_back(e);
            end else begin
                chk("R2 no stray mem_valid", 64'(mem_valid_o), 64'd0);
            end
            if (rq.size() > 0 && rq[0].cyc == cyc - 2) begin
                e = rq.pop_front();
                chk({e.tag, " res_valid R2"}, 64'(res_valid_o), 64'd1);
                chk({e.tag, " illop R8"}, 64'(illop_fault_o), 64'(e.il));
                chk({e.tag, " natc R6"}, 64'(nat_fault_o), 64'(e.nf));
                chk({e.tag, " defer R7"}, 64'(deferred_o), 64'(e.df));
                chk({e.tag, " base_we R5"}, 64'(base_we_o), 64'(e.we));
                if (e.we) chk({e.tag, " base_wdata R5"}, base_wdata_o, e.wd);
                chk({e.tag, " mod_lo R10"}, 64'(mod_lo_o), 64'(e.ml));
                chk({e.tag, " mod_hi R10"}, 64'(mod_hi_o), 64'(e.mh));
            end else begin
                chk("R2 no stray res_valid", 64'(res_valid_o), 64'd0);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R2 reset mem_valid", 64'(mem_valid_o), 64'd0);
        chk("R2 reset res_valid", 64'(res_valid_o), 64'd0);

        issue("R1 single static",    0, 0, 0,   2,   3, 64'h1000, 0, 0);
        idle(3);
        issue("R5 double upd rot",   1, 1, 0,  40,  41, 64'h2000, 0, 0);
        issue("R4 integer rrb5",     2, 1, 1,  40,  33, 64'h3008, 0, 5);
        issue("R4 wrap rrb95",       1, 0, 0, 127,  34, 64'h4000, 0, 95);
        issue("R5 single upd wrap",  0, 1, 0,   5,  36, 64'hFFFF_FFFF_FFFF_FFFC, 0, 0);
        idle(3);
        issue("R8 mixed odd rrb ok", 1, 1, 0,  10,  40, 64'h5000, 0, 3);
        issue("R8 mixed odd rrb bad",1, 1, 0,  10,  41, 64'h5000, 0, 3);
        issue("R8 static even pair", 0, 1, 0,   4,   6, 64'h6000, 0, 0);
        issue("R9 target zero",      1, 1, 0,   0,   3, 64'h7000, 0, 0);
        issue("R9 target one",       1, 0, 0,  30,   1, 64'h7000, 0, 0);
        issue("R12 form reserved",   3, 1, 0,   2,   3, 64'h7100, 0, 0);
        idle(2);
        issue("R6 nat plain",        1, 1, 0,   2,   3, 64'h8000, 1, 0);
        issue("R6 nat advanced",     0, 1, 1,  32,  33, 64'h8100, 1, 0);
        issue("R7 nat speculative",  1, 1, 2,   2,  33, 64'h8200, 1, 0);
        issue("R7 nat spec-adv",     2, 0, 3,  40,  47, 64'h8300, 1, 7);
        issue("R11 nat and illegal", 1, 1, 3,   4,   8, 64'h8400, 1, 0);
        issue("R10 both partitions", 2, 0, 0,  31,  32, 64'h9000, 0, 0);
        issue("R3 swapped order",    1, 0, 0,  33,  40, 64'h9100, 0, 1);
        idle(5);

        chk("R2 queue drained", 64'(mq.size() + rq.size()), 64'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule